// File: doc/BRIEF.md
# Speculative Load Deferred-Fault Tracker

A speculative load can be moved above the branch that guards it. This block keeps track of whether such a load faulted, without raising the fault at that point. It holds two bits for each architectural register. The first is a deferred-fault token, set when a speculative load to that register faulted. The second is a pending marker, set when a speculative load has written the register and no check has consumed it yet. A later check instruction on the register decides the outcome one cycle later. The outcome is recovery (the register carries a token), a clean pass (the register carries only a marker) or misuse (the check has no speculative load behind it).

Ordinary writes wipe both bits. An ALU result inherits a token from any source that carries one, so a faulted value can flow through dependent arithmetic silently and is caught only at the check. If the guarded path never runs a check on the register, no fault is ever signalled for it. Two source-read ports show the stored tokens of the registers an ALU operation names.

Top module: `spec_fault_tracker`

## Requirements
- R1: After reset every register has token and marker clear, and `recover_o`, `pass_o` and `misuse_o` are low.
- R2: A speculative load completion with `ld_fault_i`=1 sets the target's token and marker and raises no output. Only a later check reports the fault.
- R3: A speculative load completion with `ld_fault_i`=0 clears the target's token and sets its marker.
- R4: A check on a register whose token is set drives `recover_o` high for exactly the next cycle, with `recover_idx_o` equal to the checked index. It then clears that register's token and marker.
- R5: A check on a register with the token clear and the marker set drives `pass_o` high for the next cycle and clears the marker.
- R6: A check on a register with both the token and the marker clear drives `misuse_o` high for the next cycle.
- R7: A non-speculative write clears the target's token and marker.
- R8: An ALU write sets the destination token to the OR of the tokens of all its sources, clears the destination marker, and raises no output.
- R9: `src_tok_o[s]` shows, without delay, the stored token of the register selected by field s of `alu_rs_i`. Field s occupies bits [s*5 +: 5]. The value is the state before this cycle's updates.
- R10: When several updates target one register in the same cycle, the priority is: non-speculative write, then ALU write, then speculative load, then the clearing done by a check. A check is judged on the state before this cycle's updates.
- R11: Each check yields exactly one of recover, pass or misuse in the following cycle, and no result appears without a check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Speculative load completion |
| ld_rd_i | input | 5 | Speculative load target register |
| ld_fault_i | input | 1 | Load met a fault |
| wr_valid_i | input | 1 | Non-speculative register write |
| wr_rd_i | input | 5 | Non-speculative write target |
| alu_valid_i | input | 1 | ALU result write |
| alu_rd_i | input | 5 | ALU destination |
| alu_rs_i | input | 10 | ALU source indices, 5 bits each |
| chk_valid_i | input | 1 | Check instruction |
| chk_rs_i | input | 5 | Register named by the check |
| src_tok_o | output | 2 | Stored token of each ALU source |
| recover_o | output | 1 | Check found a deferred fault |
| recover_idx_o | output | 5 | Register needing recovery |
| pass_o | output | 1 | Check passed |
| misuse_o | output | 1 | Check without a pending speculative load |

## Verification
The assertions assume that every index input names a register that exists and that inputs are stable around the clock edge. They place no limit on several ports aiming at one register in the same cycle. The stimulus drives inputs only at the falling edge. It confines random indices to a small window of registers, so loads, writes, ALU results and checks often collide on the same register. This exercises the priority rule while every index stays legal.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    CHK_NONE,
    CHK_PASS,
    CHK_RECOVER,
    CHK_MISUSE
  } chk_res_e;
endpackage

// File: rtl/spt_state_bank.sv
module spt_state_bank #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_valid_i,
  input  logic [IDX_W-1:0]    ld_rd_i,
  input  logic                ld_fault_i,
  input  logic                wr_valid_i,
  input  logic [IDX_W-1:0]    wr_rd_i,
  input  logic                alu_valid_i,
  input  logic [IDX_W-1:0]    alu_rd_i,
  input  logic                alu_tok_i,
  input  logic                chk_valid_i,
  input  logic [IDX_W-1:0]    chk_rs_i,
  output logic [NUM_REGS-1:0] tok_o,
  output logic [NUM_REGS-1:0] mark_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic wr_hit, alu_hit, ld_hit, chk_hit;
    logic tok_d, mark_d, tok_q, mark_q;

    assign wr_hit  = wr_valid_i  && (wr_rd_i  == MY_IDX);
    assign alu_hit = alu_valid_i && (alu_rd_i == MY_IDX);
    assign ld_hit  = ld_valid_i  && (ld_rd_i  == MY_IDX);
    assign chk_hit = chk_valid_i && (chk_rs_i == MY_IDX);

    // priority: plain write > alu > spec load > check clear
    always_comb begin
      tok_d  = tok_q;
      mark_d = mark_q;
      if (wr_hit) begin
        tok_d  = 1'b0;
        mark_d = 1'b0;
      end else if (alu_hit) begin
        tok_d  = alu_tok_i;
        mark_d = 1'b0;
      end else if (ld_hit) begin
        tok_d  = ld_fault_i;
        mark_d = 1'b1;
      end else if (chk_hit) begin
        tok_d  = 1'b0;
        mark_d = 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tok_q  <= 1'b0;
        mark_q <= 1'b0;
      end else begin
        tok_q  <= tok_d;
        mark_q <= mark_d;
      end
    end

    assign tok_o[g]  = tok_q;
    assign mark_o[g] = mark_q;
  end
endmodule

// File: rtl/spt_src_read.sv
module spt_src_read #(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0]      tok_i,
  input  logic [NUM_SRC*IDX_W-1:0] rs_i,
  output logic [NUM_SRC-1:0]       src_tok_o,
  output logic                     any_tok_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_tok_o[s] = tok_i[rs_i[s*IDX_W +: IDX_W]];
  end
  assign any_tok_o = |src_tok_o;
endmodule

// File: rtl/spt_check_unit.sv
module spt_check_unit
  import spt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] tok_i,
  input  logic [NUM_REGS-1:0] mark_i,
  input  logic                chk_valid_i,
  input  logic [IDX_W-1:0]    chk_rs_i,
  output logic                recover_o,
  output logic [IDX_W-1:0]    recover_idx_o,
  output logic                pass_o,
  output logic                misuse_o
);
  chk_res_e res_d, res_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    res_d = CHK_NONE;
    if (chk_valid_i) begin
      if (tok_i[chk_rs_i])       res_d = CHK_RECOVER;
      else if (mark_i[chk_rs_i]) res_d = CHK_PASS;
      else                       res_d = CHK_MISUSE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= CHK_NONE;
      idx_q <= '0;
    end else begin
      res_q <= res_d;
      if (chk_valid_i) idx_q <= chk_rs_i;
    end
  end

  assign recover_o     = (res_q == CHK_RECOVER);
  assign pass_o        = (res_q == CHK_PASS);
  assign misuse_o      = (res_q == CHK_MISUSE);
  assign recover_idx_o = idx_q;
endmodule

// File: rtl/spec_fault_tracker.sv
module spec_fault_tracker #(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_valid_i,
  input  logic [IDX_W-1:0]         ld_rd_i,
  input  logic                     ld_fault_i,
  input  logic                     wr_valid_i,
  input  logic [IDX_W-1:0]         wr_rd_i,
  input  logic                     alu_valid_i,
  input  logic [IDX_W-1:0]         alu_rd_i,
  input  logic [NUM_SRC*IDX_W-1:0] alu_rs_i,
  input  logic                     chk_valid_i,
  input  logic [IDX_W-1:0]         chk_rs_i,
  output logic [NUM_SRC-1:0]       src_tok_o,
  output logic                     recover_o,
  output logic [IDX_W-1:0]         recover_idx_o,
  output logic                     pass_o,
  output logic                     misuse_o
);
  logic [NUM_REGS-1:0] tok, mark;
  logic                alu_tok;

  spt_state_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_valid_i  (ld_valid_i),
    .ld_rd_i     (ld_rd_i),
    .ld_fault_i  (ld_fault_i),
    .wr_valid_i  (wr_valid_i),
    .wr_rd_i     (wr_rd_i),
    .alu_valid_i (alu_valid_i),
    .alu_rd_i    (alu_rd_i),
    .alu_tok_i   (alu_tok),
    .chk_valid_i (chk_valid_i),
    .chk_rs_i    (chk_rs_i),
    .tok_o       (tok),
    .mark_o      (mark)
  );

  spt_src_read #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_src (
    .tok_i     (tok),
    .rs_i      (alu_rs_i),
    .src_tok_o (src_tok_o),
    .any_tok_o (alu_tok)
  );

  spt_check_unit #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tok_i         (tok),
    .mark_i        (mark),
    .chk_valid_i   (chk_valid_i),
    .chk_rs_i      (chk_rs_i),
    .recover_o     (recover_o),
    .recover_idx_o (recover_idx_o),
    .pass_o        (pass_o),
    .misuse_o      (misuse_o)
  );
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ld_valid_i,
  input logic                     ld_fault_i,
  input logic [NUM_SRC*IDX_W-1:0] alu_rs_i,
  input logic                     chk_valid_i,
  input logic [IDX_W-1:0]         chk_rs_i,
  input logic [NUM_SRC-1:0]       src_tok_o,
  input logic                     recover_o,
  input logic [IDX_W-1:0]         recover_idx_o,
  input logic                     pass_o,
  input logic                     misuse_o
);
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({recover_o, pass_o, misuse_o})); // R11

  AST_RESULT_NEEDS_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recover_o || pass_o || misuse_o) |-> $past(chk_valid_i)); // R11

  AST_CHECK_GIVES_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> (recover_o || pass_o || misuse_o)); // R11

  AST_RECOVER_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> (recover_idx_o == $past(chk_rs_i))); // R4

  AST_LOAD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_fault_i && !chk_valid_i) |=> !recover_o); // R2

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    AST_TOKEN_RECOVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chk_valid_i && src_tok_o[s] && (alu_rs_i[s*IDX_W +: IDX_W] == chk_rs_i))
        |=> recover_o); // R4
  end
endmodule

bind spec_fault_tracker spt_checker #(
  .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
) u_spt_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ld_valid_i    (ld_valid_i),
  .ld_fault_i    (ld_fault_i),
  .alu_rs_i      (alu_rs_i),
  .chk_valid_i   (chk_valid_i),
  .chk_rs_i      (chk_rs_i),
  .src_tok_o     (src_tok_o),
  .recover_o     (recover_o),
  .recover_idx_o (recover_idx_o),
  .pass_o        (pass_o),
  .misuse_o      (misuse_o)
);

// File: tb/tb_spec_fault_tracker.sv
module tb_spec_fault_tracker;
  localparam int NR = 32;
  logic clk_i = 0, rst_ni = 0;
  logic ld_valid_i = 0, ld_fault_i = 0, wr_valid_i = 0, alu_valid_i = 0, chk_valid_i = 0;
  logic [4:0] ld_rd_i = 0, wr_rd_i = 0, alu_rd_i = 0, chk_rs_i = 0;
  logic [9:0] alu_rs_i = 0;
  logic [1:0] src_tok_o;
  logic recover_o, pass_o, misuse_o;
  logic [4:0] recover_idx_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit m_tok[NR], m_mark[NR];
  bit e_rec = 0, e_pass = 0, e_mis = 0;
  int e_idx = 0;
  string e_tag = "R1";

  always #5 clk_i = ~clk_i;

  spec_fault_tracker dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic step(input bit lv, input int lr, input bit lf, input bit wv, input int wr,
                      input bit av, input int ar, input int s0, input int s1,
                      input bit cv, input int cr, input string tag);
    bit at;
    @(negedge clk_i);
    // results of previous step's check (R4/R5/R6/R11)
    chk({e_tag, " R4 recover"}, int'(recover_o), int'(e_rec));
    chk({e_tag, " R5 pass"}, int'(pass_o), int'(e_pass));
    chk({e_tag, " R6 misuse"}, int'(misuse_o), int'(e_mis));
    chk({e_tag, " R11 one result"}, int'(recover_o) + int'(pass_o) + int'(misuse_o),
        int'(e_rec) + int'(e_pass) + int'(e_mis));
    if (e_rec) chk({e_tag, " R4 idx"}, int'(recover_idx_o), e_idx);
    ld_valid_i = lv; ld_rd_i = 5'(lr); ld_fault_i = lf;
    wr_valid_i = wv; wr_rd_i = 5'(wr);
    alu_valid_i = av; alu_rd_i = 5'(ar); alu_rs_i = {5'(s1), 5'(s0)};
    chk_valid_i = cv; chk_rs_i = 5'(cr);
    #1;
    chk({tag, " R9 src0"}, int'(src_tok_o[0]), int'(m_tok[s0]));
    chk({tag, " R9 src1"}, int'(src_tok_o[1]), int'(m_tok[s1]));
    at = m_tok[s0] | m_tok[s1];
    e_rec = cv && m_tok[cr];
    e_pass = cv && !m_tok[cr] && m_mark[cr];
    e_mis = cv && !m_tok[cr] && !m_mark[cr];
    e_idx = cr; e_tag = tag;
    // apply in rising priority so the last writer wins (R10)
    if (cv) begin m_tok[cr] = 0; m_mark[cr] = 0; end
    if (lv) begin m_tok[lr] = lf; m_mark[lr] = 1; end
    if (av) begin m_tok[ar] = at; m_mark[ar] = 0; end
    if (wv) begin m_tok[wr] = 0; m_mark[wr] = 0; end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic chk_reg(input int r, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, r, r, 1, r, tag);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin m_tok[i] = 0; m_mark[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state, all tokens clear, check misuses
    for (int i = 0; i < NR; i += 2) step(0, 0, 0, 0, 0, 0, 0, i, i + 1, 0, 0, "R1");
    chk_reg(5, "R1");
    idle("R6");
    // R2: faulting load silent, later check recovers (R4), second check misuses
    step(1, 3, 1, 0, 0, 0, 0, 3, 0, 0, 0, "R2");
    idle("R2");
    chk_reg(3, "R4");
    chk_reg(3, "R4");
    // R3: clean load then pass (R5), then misuse
    step(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    chk_reg(4, "R5");
    chk_reg(4, "R5");
    // R7: plain write clears token
    step(1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 6, 0, 0, 6, 0, 0, 0, "R7");
    chk_reg(6, "R7");
    // R8: token propagates through ALU
    step(1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 8, 1, 7, 0, 0, "R8");
    chk_reg(8, "R8");
    step(0, 0, 0, 0, 0, 1, 9, 1, 2, 0, 0, "R8");
    chk_reg(9, "R8");
    // R10: same-cycle collisions
    step(1, 10, 1, 1, 10, 0, 0, 0, 0, 0, 0, "R10");
    chk_reg(10, "R10");
    step(1, 11, 1, 0, 0, 0, 0, 0, 0, 1, 11, "R10");
    chk_reg(11, "R10");
    step(1, 12, 1, 0, 0, 1, 12, 0, 1, 0, 0, "R10");
    chk_reg(12, "R10");
    // mixed traffic on a narrow register window
    for (int n = 0; n < 4000; n++) begin
      int b;
      b = (n / 500) * 4;
      step($urandom_range(0, 1), b + $urandom_range(0, 3), $urandom_range(0, 1),
           ($urandom_range(0, 3) == 0), b + $urandom_range(0, 3),
           $urandom_range(0, 1), b + $urandom_range(0, 3),
           b + $urandom_range(0, 3), b + $urandom_range(0, 3),
           $urandom_range(0, 1), b + $urandom_range(0, 3), "R10 mix");
    end
    idle("R11");
    idle("R11");
    finish_run();
  end
endmodule